// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for a small CPU and presents one of them at a time as a 16-bit vector address. The sources are two external pins, which are active low, two timer overflow pulses and a serial request level. A configuration write port loads three registers: a source-enable register with a global mask bit, a priority register with one high/low bit for each source, and a trigger-type register for the two external pins. Each external pin either requests while it is held low, or latches a falling edge into an edge flag that the controller clears itself.

When an enabled request is allowed to interrupt, the controller raises `irqReq` and drives `irqVector`. The CPU answers with a one-cycle `irqAck`, and the controller then marks that priority level as in service. The CPU ends a handler with a one-cycle `retiPulse`, which releases the most recent level. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler, and a low-level request waits while a low-level handler runs. Within a level, ties are broken by a fixed order.

Source index, used in every register and in the tie-break order: 0 = external pin 0, 1 = timer 0, 2 = external pin 1, 3 = timer 1, 4 = serial.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every enable bit is zero, so no request is presented even when sources are active, and both in-service indicators are low.
- R2: While the global bit (enable register bit 7) is 0, `irqReq` stays low whatever the per-source bits are.
- R3: The configuration addresses are 0 = enable, 1 = priority and 2 = trigger type. In the enable register, bits 0 to 4 enable sources 0 to 4, and a source whose bit is 0 never requests.
- R4: The vector for source k is 0003h + 8·k, giving 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R5: Among pending requests of the same level, the source with the lowest index is presented.
- R6: Priority register bits 0 to 4 mark sources 0 to 4 as high (1) or low (0), and a pending high request is presented before any low one.
- R7: A high request is presented while a low handler is in service. No request is presented while a high handler is in service. A low request is held back while a low handler is in service.
- R8: An `irqAck` given while `irqReq` is high sets the in-service bit of the presented level. An `irqAck` given while `irqReq` is low has no effect. `retiPulse` clears the high in-service bit if it is set, and otherwise the low one.
- R9: A timer overflow pulse sets that timer's flag, and acknowledging that source clears the flag. The serial request is not cleared by the controller and keeps requesting after the handler returns.
- R10: When trigger-type bit 0 (pin 0) or bit 1 (pin 1) is 1, a falling edge on the pin, seen as high then low on consecutive synchronized samples, sets an edge flag. This happens even while the source is disabled. The flag is cleared on acknowledge, so a pin that is still held low does not request again.
- R11: When the trigger-type bit is 0, the pin requests for as long as it is low. The request returns after a return from the handler while the pin stays low, and it stops when the pin goes high, with no acknowledge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 enable, 1 priority, 2 trigger type |
| cfgWrData | input | 8 | Write data |
| extPinN | input | 2 | Active-low external interrupt pins (asynchronous) |
| tmrOvf | input | 2 | Timer 0 / timer 1 overflow pulses |
| serialReq | input | 1 | Serial transmit-or-receive request level |
| irqAck | input | 1 | CPU acknowledge of the presented request |
| retiPulse | input | 1 | CPU return-from-interrupt pulse |
| irqReq | output | 1 | A request is presented |
| irqVector | output | 16 | Vector address of the presented request |
| inSvcHigh | output | 1 | A high-level handler is in service |
| inSvcLow | output | 1 | A low-level handler is in service |

## Verification
The bench builds the block with a three-stage pin synchronizer instead of the default two. This exercises the parameterized synchronizer path and moves edge detection one cycle later, so the bench waits a fixed margin before it samples external requests. The vector base and stride keep their defaults, which makes all five fixed addresses observable. The directed tests reach nested preemption (a high handler over a low one, followed by two returns in order), edges latched while a source is disabled, and a level request that withdraws without an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NumSrc = 5;
  localparam int NumExt = 2;
  localparam int IdxW   = $clog2(NumSrc);

  // sources whose request flag the controller clears on acknowledge
  // (externals and timers; serial is left to software)
  localparam logic [NumSrc-1:0] HwClearMask = 5'b01111;

  typedef enum logic [1:0] {
    CFG_ENABLE   = 2'd0,
    CFG_PRIORITY = 2'd1,
    CFG_TRIGGER  = 2'd2
  } cfgAddr_e;

  typedef struct packed {
    logic [NumSrc-1:0] clrFlag;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic [NumExt-1:0] extPinN,
  input  logic [NumExt-1:0] tmrOvf,
  input  logic              serialReq,
  input  ctlStrobe_t        strobe,
  output logic              globalEn,
  output logic [NumSrc-1:0] pending,
  output logic [NumSrc-1:0] prioMask
);
  logic              eaBit;
  logic [NumSrc-1:0] enMask;
  logic [NumSrc-1:0] prMask;
  logic [NumExt-1:0] trigEdge;
  logic [NumSrc-1:0] rawReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaBit    <= 1'b0;
      enMask   <= '0;
      prMask   <= '0;
      trigEdge <= '0;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        CFG_ENABLE: begin
          eaBit  <= cfgWrData[7];
          enMask <= cfgWrData[NumSrc-1:0];
        end
        CFG_PRIORITY: prMask   <= cfgWrData[NumSrc-1:0];
        CFG_TRIGGER:  trigEdge <= cfgWrData[NumExt-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NumExt; i++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncQ;
    logic pinPrev;
    logic fallEdge;
    logic edgeFlag;
    logic tmrFlag;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '1;
        pinPrev <= 1'b1;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], extPinN[i]};
        pinPrev <= syncQ[SYNC_STAGES-1];
      end
    end

    assign fallEdge = pinPrev & ~syncQ[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       edgeFlag <= 1'b0;
      else if (!trigEdge[i])           edgeFlag <= 1'b0;
      else if (fallEdge)               edgeFlag <= 1'b1;
      else if (strobe.clrFlag[2*i])    edgeFlag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         tmrFlag <= 1'b0;
      else if (tmrOvf[i])                tmrFlag <= 1'b1;
      else if (strobe.clrFlag[2*i+1])    tmrFlag <= 1'b0;
    end

    assign rawReq[2*i]   = trigEdge[i] ? edgeFlag : ~syncQ[SYNC_STAGES-1];
    assign rawReq[2*i+1] = tmrFlag;

    p_tmr_set_r9: assert property (@(posedge clk) disable iff (!rstN)
      tmrOvf[i] |=> tmrFlag);
    p_tmr_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrFlag[2*i+1] && !tmrOvf[i] |=> !tmrFlag);
    p_edge_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrFlag[2*i] && !fallEdge |=> !edgeFlag);
  end

  assign rawReq[NumSrc-1] = serialReq;
  assign pending  = rawReq & enMask & {NumSrc{eaBit}};
  assign globalEn = eaBit;
  assign prioMask = prMask;
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int          VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] pending,
  input  logic [NumSrc-1:0] prioMask,
  input  logic              globalEn,
  input  logic              irqAck,
  input  logic              retiPulse,
  output logic              irqReq,
  output logic [15:0]       irqVector,
  output logic              inSvcHigh,
  output logic              inSvcLow,
  output ctlStrobe_t        strobe
);
  logic [NumSrc-1:0] hiPend;
  logic [NumSrc-1:0] loPend;
  logic [IdxW-1:0]   selIdx;
  logic              selHi;
  logic              reqValid;
  logic              ackFire;
  logic              svcHi;
  logic              svcLo;

  function automatic logic [IdxW-1:0] firstSet(input logic [NumSrc-1:0] v);
    firstSet = '0;
    for (int k = NumSrc - 1; k >= 0; k--) begin
      if (v[k]) firstSet = IdxW'(k);
    end
  endfunction

  assign hiPend = pending & prioMask;
  assign loPend = pending & ~prioMask;

  always_comb begin
    reqValid = 1'b0;
    selHi    = 1'b0;
    selIdx   = '0;
    if (!svcHi) begin
      if (|hiPend) begin
        reqValid = 1'b1;
        selHi    = 1'b1;
        selIdx   = firstSet(hiPend);
      end else if (!svcLo && |loPend) begin
        reqValid = 1'b1;
        selIdx   = firstSet(loPend);
      end
    end
  end

  assign ackFire        = irqAck & reqValid;
  assign strobe.clrFlag = ackFire ? ((NumSrc'(1) << selIdx) & HwClearMask) : '0;

  // acknowledge wins over a return arriving in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcHi <= 1'b0;
      svcLo <= 1'b0;
    end else if (ackFire) begin
      if (selHi) svcHi <= 1'b1;
      else       svcLo <= 1'b1;
    end else if (retiPulse) begin
      if (svcHi) svcHi <= 1'b0;
      else       svcLo <= 1'b0;
    end
  end

  assign irqReq    = reqValid;
  assign irqVector = VEC_BASE + 16'(VEC_STRIDE) * 16'(selIdx);
  assign inSvcHigh = svcHi;
  assign inSvcLow  = svcLo;

  p_ea_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq);
  p_hi_blocks_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    inSvcHigh |-> !irqReq);
  p_lo_no_nest_r7: assert property (@(posedge clk) disable iff (!rstN)
    inSvcLow && irqReq |-> (pending & prioMask) != '0);
  p_ack_sets_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && irqReq && (pending & prioMask) == '0 |=> inSvcLow);
  p_reti_hi_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    retiPulse && !irqAck && inSvcHigh |=> !inSvcHigh && inSvcLow == $past(inSvcLow));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter int          VEC_STRIDE  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgAddr,
  input  logic [7:0]  cfgWrData,
  input  logic [1:0]  extPinN,
  input  logic [1:0]  tmrOvf,
  input  logic        serialReq,
  input  logic        irqAck,
  input  logic        retiPulse,
  output logic        irqReq,
  output logic [15:0] irqVector,
  output logic        inSvcHigh,
  output logic        inSvcLow
);
  ctlStrobe_t        strobe;
  logic              globalEn;
  logic [NumSrc-1:0] pending;
  logic [NumSrc-1:0] prioMask;

  irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .extPinN(extPinN), .tmrOvf(tmrOvf),
    .serialReq(serialReq), .strobe(strobe), .globalEn(globalEn),
    .pending(pending), .prioMask(prioMask)
  );

  irq_control #(.VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) ctl_i (
    .clk(clk), .rstN(rstN), .pending(pending), .prioMask(prioMask),
    .globalEn(globalEn), .irqAck(irqAck), .retiPulse(retiPulse),
    .irqReq(irqReq), .irqVector(irqVector), .inSvcHigh(inSvcHigh),
    .inSvcLow(inSvcLow), .strobe(strobe)
  );
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [1:0]  extPinN = 2'b11;
  logic [1:0]  tmrOvf = '0;
  logic        serialReq = 1'b0;
  logic        irqAck = 1'b0;
  logic        retiPulse = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;
  logic        inSvcHigh;
  logic        inSvcLow;
  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .extPinN(extPinN), .tmrOvf(tmrOvf),
    .serialReq(serialReq), .irqAck(irqAck), .retiPulse(retiPulse),
    .irqReq(irqReq), .irqVector(irqVector), .inSvcHigh(inSvcHigh),
    .inSvcLow(inSvcLow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic reti();
    @(negedge clk); retiPulse = 1'b1;
    @(negedge clk); retiPulse = 1'b0;
  endtask

  task automatic pulseTmr(input logic [1:0] which);
    @(negedge clk); tmrOvf = which;
    @(negedge clk); tmrOvf = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    serialReq = 1'b1; pulseTmr(2'b11);
    settle(1);
    check("R1 no request after reset", irqReq, 0);
    check("R1 high svc clear", inSvcHigh, 0);
    check("R1 low svc clear", inSvcLow, 0);
    ack();
    check("R8 stray ack ignored", {inSvcHigh, inSvcLow}, 0);
  endtask

  task automatic t_enables();
    writeCfg(2'd0, 8'h1F);
    check("R2 global bit off masks", irqReq, 0);
    writeCfg(2'd0, 8'h90);
    check("R3 serial enabled requests", irqReq, 1);
    check("R4 serial vector", irqVector, 16'h0023);
    writeCfg(2'd0, 8'h80);
    check("R3 per-source bit off masks", irqReq, 0);
  endtask

  task automatic t_order();
    writeCfg(2'd0, 8'h9F);
    check("R5 timer 0 first", irqVector, 16'h000B);
    ack();
    check("R8 low svc set", inSvcLow, 1);
    check("R7 low blocks low", irqReq, 0);
    reti();
    check("R8 reti clears low", inSvcLow, 0);
    check("R9 timer 0 flag cleared", irqVector, 16'h001B);
    ack(); reti();
    check("R9 timer 1 flag cleared", irqVector, 16'h0023);
    ack(); reti();
    check("R9 serial still requests", irqReq, 1);
    check("R9 serial vector again", irqVector, 16'h0023);
    serialReq = 1'b0; settle(1);
    check("R9 serial withdrawn", irqReq, 0);
  endtask

  task automatic t_priority();
    writeCfg(2'd1, 8'h10);
    serialReq = 1'b1; pulseTmr(2'b01);
    check("R6 high serial beats low timer", irqVector, 16'h0023);
    ack();
    check("R8 high svc set", inSvcHigh, 1);
    check("R7 nothing over high", irqReq, 0);
    reti();
    check("R8 reti clears high", inSvcHigh, 0);
    serialReq = 1'b0; settle(1);
    check("R6 low timer now", irqVector, 16'h000B);
    ack();
    check("R8 low svc for timer", inSvcLow, 1);
    serialReq = 1'b1; settle(1);
    check("R7 high preempts low", irqReq, 1);
    check("R4 preempt vector", irqVector, 16'h0023);
    ack();
    check("R7 nested both set", {inSvcHigh, inSvcLow}, 2'b11);
    serialReq = 1'b0;
    reti();
    check("R8 reti releases high first", {inSvcHigh, inSvcLow}, 2'b01);
    reti();
    check("R8 second reti releases low", {inSvcHigh, inSvcLow}, 2'b00);
    writeCfg(2'd1, 8'h00);
  endtask

  task automatic t_edge();
    writeCfg(2'd2, 8'h01);
    writeCfg(2'd0, 8'h81);
    check("R10 idle pin no request", irqReq, 0);
    extPinN[0] = 1'b0; settle(8);
    check("R10 falling edge requests", irqReq, 1);
    check("R4 pin 0 vector", irqVector, 16'h0003);
    ack(); reti(); settle(2);
    check("R10 held low no rerequest", irqReq, 0);
    extPinN[0] = 1'b1; settle(6);
    writeCfg(2'd0, 8'h80);
    extPinN[0] = 1'b0; settle(8);
    extPinN[0] = 1'b1; settle(6);
    writeCfg(2'd0, 8'h81);
    check("R10 edge latched while disabled", irqReq, 1);
    ack(); reti();
    check("R10 flag cleared by ack", irqReq, 0);
  endtask

  task automatic t_level();
    writeCfg(2'd2, 8'h00);
    writeCfg(2'd0, 8'h84);
    extPinN[1] = 1'b0; settle(8);
    check("R11 low level requests", irqReq, 1);
    check("R4 pin 1 vector", irqVector, 16'h0013);
    ack(); reti();
    check("R11 level persists", irqReq, 1);
    writeCfg(2'd0, 8'h85);
    extPinN[0] = 1'b0; settle(8);
    check("R5 pin 0 over pin 1", irqVector, 16'h0003);
    extPinN = 2'b11; settle(8);
    check("R11 released without ack", irqReq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_enables();
    t_order();
    t_priority();
    t_edge();
    t_level();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule